// File: doc/BRIEF.md
# Maskable Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core. Requests arrive as a vector of level signals and are captured into a pending register. Each pending request is gated by its bit in a writable mask register. A fixed priority encoder then names the single source to service. Source 0 is the powerdown request. The mask never gates it, and it outranks every other source. Among the remaining sources, a lower index means a higher priority.

A small state machine governs when servicing is allowed. It has three states:
- `ST_RUN`: servicing is open.
- `ST_HOLD`: a one-cycle blackout entered after any mask write.
- `ST_OFF`: servicing is globally disabled. The mask contents are left as they are.

The transitions are:
- `RUN->HOLD` and `OFF->HOLD` on a mask write. `OFF->HOLD` happens only when an enable arrives in the same cycle.
- `HOLD->RUN` after the single blackout cycle.
- `RUN->OFF`, `HOLD->OFF` and `OFF->OFF` on a disable command. Disable wins over every other input in the same cycle.
- `OFF->RUN` on an enable command.
- `OFF->OFF` on a mask write with no enable.

The core acknowledges a serviced source with a one-cycle pulse, which clears that source's pending bit.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `svc_valid` is 0, `svc_idx` is 0, `mask_rd` is all zeros (every maskable source masked), and the state machine is in `ST_RUN` with servicing enabled.
- R2: A request bit high at a rising edge sets its pending bit at that edge. If the source is eligible, `svc_valid` and `svc_idx` reflect it during the cycle that follows that edge.
- R3: A source i >= 1 is eligible only while mask bit i is 1 (1 = unmasked). A masked request stays pending and is serviced once its mask bit is set.
- R4: When several sources are eligible, `svc_idx` names the one with the lowest index.
- R5: Source 0 (powerdown) is eligible whenever it is pending, whatever the value of mask bit 0. It therefore outranks all other sources.
- R6: A `mask_we` pulse loads `mask_wdata` into the mask at that edge. `svc_valid` is then 0 for exactly the one following cycle, after which servicing resumes unless a disable intervened.
- R7: An `int_dis_cmd` pulse forces `svc_valid` to 0 from the next cycle until an enable arrives, and leaves `mask_rd` unchanged. When enable and disable arrive together, disable wins.
- R8: An `int_en_cmd` pulse while disabled reopens servicing from the next cycle. A mask write while disabled without an enable leaves servicing disabled.
- R9: `svc_ack` while `svc_valid` is 1 clears the pending bit of the source named by `svc_idx`. The next eligible source, if any, appears in the following cycle.
- R10: Whenever `svc_valid` is 0, `svc_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Level interrupt requests, bit 0 is powerdown |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_SRC | New mask value, 1 = unmasked |
| int_en_cmd | input | 1 | Global enable command pulse |
| int_dis_cmd | input | 1 | Global disable command pulse |
| svc_ack | input | 1 | Acknowledge of the source named by svc_idx |
| svc_valid | output | 1 | A source is selected for service |
| svc_idx | output | IDX_W | Index of the selected source |
| mask_rd | output | NUM_SRC | Current mask register contents |

## Verification
The assertions assume the following about the inputs:
- Commands and the acknowledge are single-cycle pulses.
- `svc_ack` is raised only while `svc_valid` is 1.
- Requests are synchronous to `clk` and meet setup, which is why the default design uses no synchroniser stage.

The stimulus drives every input half a cycle away from the active edge and pulses each command for one row only. It lowers a request before that source is acknowledged, so a level request never re-pends a source in the cycle it is cleared.

// File: rtl/irq_arbiter_pkg.sv
package irq_arbiter_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_OFF  = 2'd2
    } gate_state_t;

    function automatic logic [31:0] onehot_of(input int unsigned idx);
        logic [31:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] pend_q
);

    logic [NUM_SRC-1:0] req_s;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign req_s = req_in;
        end else begin : g_sync
            logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
                end else begin
                    sync_q[0] <= req_in;
                    for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
                end
            end
            assign req_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // A fresh request wins over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | req_s;
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_SRC = 8,
    parameter int PD_IDX  = 0,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               open,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_SRC-1:0] elig;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
            if (i == PD_IDX) begin : g_nmi
                assign elig[i] = pend[i] & open;
            end else begin : g_mask
                assign elig[i] = pend[i] & mask[i] & open;
            end
        end
    endgenerate

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        // powerdown outranks all regardless of its index
        if (elig[PD_IDX]) idx = IDX_W'(PD_IDX);
    end

endmodule

// File: rtl/irq_gate_fsm.sv
module irq_gate_fsm
    import irq_arbiter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask_we,
    input  logic en_cmd,
    input  logic dis_cmd,
    output logic open
);

    gate_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (dis_cmd)      state_d = ST_OFF;
                else if (mask_we) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (dis_cmd)      state_d = ST_OFF;
                else if (mask_we) state_d = ST_HOLD;
                else              state_d = ST_RUN;
            end
            ST_OFF: begin
                if (dis_cmd)                state_d = ST_OFF;
                else if (en_cmd && mask_we) state_d = ST_HOLD;
                else if (en_cmd)            state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  open = 1'b1;
            ST_HOLD: open = 1'b0;
            ST_OFF:  open = 1'b0;
            default: open = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arbiter_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 0,
    localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               int_en_cmd,
    input  logic               int_dis_cmd,
    input  logic               svc_ack,
    output logic               svc_valid,
    output logic [IDX_W-1:0]   svc_idx,
    output logic [NUM_SRC-1:0] mask_rd
);

    localparam int PD_IDX = 0;

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr_vec;
    logic               open;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign clr_vec = (svc_ack && svc_valid)
                   ? NUM_SRC'(onehot_of(int'(svc_idx))) : '0;

    irq_pending #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (irq_req),
        .clr_vec (clr_vec),
        .pend_q  (pend)
    );

    irq_gate_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .en_cmd  (int_en_cmd),
        .dis_cmd (int_dis_cmd),
        .open    (open)
    );

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .PD_IDX(PD_IDX)) u_enc (
        .pend (pend),
        .mask (mask_q),
        .open (open),
        .any  (svc_valid),
        .idx  (svc_idx)
    );

    assign mask_rd = mask_q;

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mask_we,
    input logic [NUM_SRC-1:0] mask_wdata,
    input logic               int_dis_cmd,
    input logic               svc_valid,
    input logic [IDX_W-1:0]   svc_idx,
    input logic [NUM_SRC-1:0] mask_rd
);

    p_blackout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> !svc_valid);

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_rd == $past(mask_wdata));

    p_mask_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_rd));

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_dis_cmd |=> !svc_valid);

    p_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (svc_idx == '0 || mask_rd[svc_idx]));

    p_idx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_valid |-> svc_idx == '0);

endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .int_dis_cmd (int_dis_cmd),
    .svc_valid   (svc_valid),
    .svc_idx     (svc_idx),
    .mask_rd     (mask_rd)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;

    localparam int N = 8;
    localparam int W = 3;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         int_en_cmd = 1'b0;
    logic         int_dis_cmd = 1'b0;
    logic         svc_ack = 1'b0;
    logic         svc_valid;
    logic [W-1:0] svc_idx;
    logic [N-1:0] mask_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_arbiter #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .int_en_cmd(int_en_cmd),
        .int_dis_cmd(int_dis_cmd), .svc_ack(svc_ack),
        .svc_valid(svc_valid), .svc_idx(svc_idx), .mask_rd(mask_rd)
    );

    // {req, we, wdata, en, dis, ack, exp_valid, exp_idx, exp_mask}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}, // idle R10
        {8'h04, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}, // masked R3
        {8'h00, 1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h0C}, // blackout R6
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 8'h0C}, // resume R6 R3
        {8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 8'h0C}, // lower wins R4 R2
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 8'h0C}, // ack R9
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h0C}, // disable R7
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h0C}, // stays off R7
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 8'h0C}, // enable R8
        {8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h0C}, // powerdown R5
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 8'h0C}, // ack pd R9
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h0C}, // dis wins R7
        {8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}, // write off R8
        {8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}, // on, masked R3
        {8'h80, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hFF}, // blackout R6
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 8'hFF}, // R4
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd7, 8'hFF}, // R9
        {8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'hFF}  // drained R10
    };

    task automatic check(input string req, input logic v, input logic [W-1:0] ix,
                         input logic [N-1:0] m);
        n_chk++;
        if (svc_valid !== v || svc_idx !== ix || mask_rd !== m) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b idx=%0d mask=%h, expected valid=%0b idx=%0d mask=%h",
                     req, svc_valid, svc_idx, mask_rd, v, ix, m);
        end
    endtask

    task automatic step(input logic [N-1:0] rq, input logic we, input logic [N-1:0] wd,
                        input logic en, input logic dis, input logic ack);
        @(negedge clk);
        irq_req = rq; mask_we = we; mask_wdata = wd;
        int_en_cmd = en; int_dis_cmd = dis; svc_ack = ack;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 3'd0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [31:0] e;
            e = VEC[k];
            step(e[31:24], e[23], e[22:15], e[14], e[13], e[12]);
            check($sformatf("vector %0d (R2-R10)", k), e[11], e[10:8], e[7:0]);
        end

        // R5 R6: powerdown pending is still held off by the blackout cycle
        step(8'h01, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R6 blackout over powerdown", 1'b0, 3'd0, 8'h00);
        step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R5 powerdown with mask zero", 1'b1, 3'd0, 8'h00);
        // R6: back-to-back mask writes extend the hold one cycle per write
        step(8'h00, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
        check("R6 first write", 1'b0, 3'd0, 8'h02);
        step(8'h00, 1'b1, 8'h06, 1'b0, 1'b0, 1'b0);
        check("R6 second write", 1'b0, 3'd0, 8'h06);
        step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R6 reopened", 1'b1, 3'd0, 8'h06);
        // R1: reset mid-run clears pending and mask
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", 1'b0, 3'd0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R1 nothing pending after reset", 1'b0, 3'd0, 8'h00);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule